// File: doc/BRIEF.md
# Direction-Flag Synchronous FIFO

This block is a first-in/first-out queue for a producer and a consumer that share one clock. Words go into a dual-port synchronous RAM used as a ring: a write address and a read address each step forward by one on their own enable and wrap from the top entry back to entry 0. The default ring holds 256 words of 16 bits.

When the two addresses are equal, the ring is either completely full or completely empty. The block tells these apart with a one-bit direction register instead of an extra address bit or an occupancy counter. A write with no read in the same cycle marks the ring as growing. A read with no write marks it as shrinking. A cycle that has both, or neither, leaves the mark as it is. `full` is the growing mark combined with equal addresses, and `empty` is the shrinking mark combined with equal addresses.

The producer must never write while `full` is high, and the consumer must never read while `empty` is high. The block does not guard against either misuse. Read data comes from the RAM's output register and appears on `d_out` one clock after `rd_en` is sampled.

Top module: `dflag_fifo`

## Requirements
- R1: While reset is held, and after it is released until the first access, `empty` is 1, `full` is 0 and `d_out` is 0.
- R2: Words leave in the order they entered. The word for a read sampled at a clock edge is on `d_out` right after that edge.
- R3: From a state that is not full, `full` becomes 1 right after the edge that stores the word bringing the occupancy to the full depth (256 by default). It stays 0 before that edge.
- R4: `empty` becomes 1 right after the edge that takes out the last stored word, with no write in the same cycle.
- R5: A cycle with both a write and a read changes neither `full` nor `empty`.
- R6: Both addresses wrap from the last entry to entry 0, so data order holds across any number of trips around the ring. Whenever `full` or `empty` is 1, the two addresses are equal.
- R7: `full` and `empty` are never both 1.
- R8: `d_out` keeps its value in every cycle where `rd_en` is 0.
- R9: One read with no write from the full state clears `full` at once. One write with no read then sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low reset: takes effect at once, released on the clock |
| wr_en | input | 1 | Store `d_in` at this edge |
| d_in | input | DATA_W | Word to store |
| rd_en | input | 1 | Take the oldest word at this edge |
| d_out | output | DATA_W | Word taken by the previous read |
| full | output | 1 | Every entry holds unread data |
| empty | output | 1 | No entry holds unread data |

## Verification
The hardest states to reach are those where the addresses are equal after the ring has gone around at least once. Only long runs reach them. The stimulus fills the ring from empty with writes alone, pulls one word out and puts it back at the boundary, and drains to half depth. It then holds simultaneous reads and writes for more than a full lap, so both addresses wrap while the occupancy stays fixed. Finally it drains to empty. A scoreboard queue checks every word that comes out against the order it went in.

// File: rtl/dflag_fifo_pkg.sv
package dflag_fifo_pkg;
  typedef enum logic {
    DIR_SHRINK = 1'b0,
    DIR_GROW   = 1'b1
  } dir_e;
endpackage

// File: rtl/dflag_rst_sync.sv
module dflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dflag_wrap_ptr.sv
module dflag_wrap_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (ptr_q == {ADDR_W{1'b1}})) |=> (ptr_q == '0));
endmodule

// File: rtl/dflag_dir_ctrl.sv
module dflag_dir_ctrl
  import dflag_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic addr_eq,
  output logic full,
  output logic empty
);
  dir_e dir_q;
  dir_e dir_d;

  always_comb begin
    dir_d = dir_q;
    unique case ({push, pop})
      2'b10:   dir_d = DIR_GROW;
      2'b01:   dir_d = DIR_SHRINK;
      default: dir_d = dir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= DIR_SHRINK;
    else        dir_q <= dir_d;
  end

  assign full  = addr_eq && (dir_q == DIR_GROW);
  assign empty = addr_eq && (dir_q == DIR_SHRINK);

  // R9
  pop_leaves_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && !push) |=> !full);
endmodule

// File: rtl/dflag_dp_ram.sv
module dflag_dp_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rd_q));
endmodule

// File: rtl/dflag_fifo.sv
module dflag_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] d_in,
  input  logic              rd_en,
  output logic [DATA_W-1:0] d_out,
  output logic              full,
  output logic              empty
);
  localparam int NPORT = 2;
  localparam int WP    = 0;
  localparam int RP    = 1;

  logic              srst_n;
  logic [NPORT-1:0]  adv;
  logic [ADDR_W-1:0] ptr [NPORT];
  logic              addr_eq;

  dflag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign adv[WP] = wr_en;
  assign adv[RP] = rd_en;

  for (genvar g = 0; g < NPORT; g++) begin : g_ptr
    dflag_wrap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(srst_n), .adv(adv[g]), .ptr(ptr[g]));
  end

  assign addr_eq = (ptr[WP] == ptr[RP]);

  dflag_dir_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .push(wr_en), .pop(rd_en),
    .addr_eq(addr_eq), .full(full), .empty(empty));

  dflag_dp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(srst_n),
    .we(wr_en), .waddr(ptr[WP]), .wdata(d_in),
    .re(rd_en), .raddr(ptr[RP]), .rdata(d_out));

  // R3
  last_write_fills_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !rd_en && ((ptr[WP] + ADDR_W'(1)) == ptr[RP])) |=> full);

  // R4
  last_read_empties_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !wr_en && ((ptr[RP] + ADDR_W'(1)) == ptr[WP])) |=> empty);

  // R5
  both_keep_flags_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && rd_en) |=> ($stable(full) && $stable(empty)));

  // R6
  flag_means_equal_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (full || empty) |-> (ptr[WP] == ptr[RP]));
endmodule

// File: tb/dflag_fifo_bench.sv
module dflag_fifo_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [DW-1:0] d_in;
  logic [DW-1:0] d_out;
  logic full, empty;

  int checks = 0;
  int fails  = 0;
  int seq    = 0;
  bit rd_seen = 1'b0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  dflag_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dflag_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .d_in(d_in),
    .rd_en(rd_en), .d_out(d_out), .full(full), .empty(empty));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, return at the next falling edge
  task automatic step(input bit w, input bit r);
    logic [DW-1:0] v;
    v = DW'(16'hA5C3 ^ (seq * 16'd613));
    wr_en = w;
    rd_en = r;
    d_in  = w ? v : '0;
    if (w) begin
      exp_q.push_back(v);
      seq++;
    end
    @(negedge clk);
  endtask

  // scoreboard monitor: R2 order and latency
  always @(posedge clk) rd_seen <= rst_n && rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 underrun", d_out, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(d_out == e, "R2", d_out, e);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] hold;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; d_in = '0;
    repeat (3) @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0, "R1 in reset", {full, empty}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(d_out == '0, "R1 d_out", d_out, 0);

    // short burst
    for (int k = 0; k < 5; k++) step(1, 0);
    chk(empty == 1'b0, "R4 not empty", empty, 0);
    for (int k = 0; k < 5; k++) step(0, 1);
    step(0, 0);
    chk(empty == 1'b1, "R4 drained", empty, 1);
    chk(full == 1'b0, "R7", full, 0);

    // fill to the limit
    for (int k = 0; k < DEPTH - 1; k++) step(1, 0);
    chk(full == 1'b0, "R3 one short", full, 0);
    chk(empty == 1'b0, "R3 one short empty", empty, 0);
    step(1, 0);
    chk(full == 1'b1, "R3 at depth", full, 1);
    chk(empty == 1'b0, "R7 full not empty", empty, 0);

    // boundary: one out, one back in
    step(0, 1);
    chk(full == 1'b0, "R9 read clears", full, 0);
    step(1, 0);
    chk(full == 1'b1, "R9 write sets", full, 1);

    // drain half, then steady lap with both ports (R5, R6)
    for (int k = 0; k < DEPTH / 2; k++) step(0, 1);
    for (int k = 0; k < DEPTH + 40; k++) begin
      step(1, 1);
      if (full || empty) chk(1'b0, "R5 flag moved", {full, empty}, 0);
    end
    chk(full == 1'b0 && empty == 1'b0, "R5 after lap", {full, empty}, 0);

    // single item with simultaneous access (R5 near empty)
    for (int k = 0; k < DEPTH / 2 - 1; k++) step(0, 1);
    chk(empty == 1'b0, "R4 one left", empty, 0);
    for (int k = 0; k < 10; k++) step(1, 1);
    chk(empty == 1'b0 && full == 1'b0, "R5 one item", {full, empty}, 0);
    step(0, 1);
    chk(empty == 1'b1, "R4 last out", empty, 1);
    step(0, 0);

    // R8: output holds while idle
    hold = d_out;
    for (int k = 0; k < 6; k++) step(0, 0);
    chk(d_out == hold, "R8 hold", d_out, hold);
    step(1, 0);
    chk(d_out == hold, "R8 write only", d_out, hold);
    step(0, 1);
    step(0, 0);
    chk(empty == 1'b1, "R6 end empty", empty, 1);
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    finished = 1'b1;
    summary();
  end
endmodule